// File: doc/BRIEF.md
# Slot-Table Memory Arbiter

This block decides which of up to fifteen memory clients may use the memory in each access cycle. A programmable schedule of sixty-four slots is kept for every memory region, and each slot names the client that owns it. A region's slot pointer walks through its schedule, one step per arbitration cycle. When the owner of the current slot is requesting, the owner wins. When the owner is idle, the slot goes to the requesting client with the lowest index, so bandwidth nobody reserved is still used.

Software fills the schedules one entry at a time through a small write port, naming a region, a slot number and a client index. Every cycle, the region input chooses which schedule and pointer serve the requests. The decision is registered and appears one cycle later as a one-hot grant vector together with a valid flag and the winning index.

Top module: `slot_table_arbiter`

## Requirements
- R1: After reset, grant valid is low, the grant vector is zero, every pointer is at slot 0 and every slot of every region is owned by client 0.
- R2: In the cycle after any request line is high, gnt_valid_o is 1, gnt_idx_o names a client that was requesting, and gnt_o is one-hot with bit gnt_idx_o set.
- R3: When the owner of the current slot is requesting, it is granted even if lower-index clients are also requesting.
- R4: When the owner of the current slot is not requesting, the grant goes to the lowest-index requesting client.
- R5: In the cycle after no request line is high, gnt_valid_o is 0 and gnt_o is zero, and the pointer of the selected region does not move.
- R6: Each cycle with at least one request moves the selected region's pointer forward by one slot, from 63 back to 0, so entry k is used on the k-th such cycle (counted from 0, modulo 64).
- R7: Each region (region_i 0 or 1) has its own schedule and pointer. Arbitration in one region neither reads nor moves the other region's schedule or pointer.
- R8: With cfg_we_i high, the entry (cfg_region_i, cfg_slot_i) takes the value cfg_client_i at the clock edge. If arbitration reads that same entry in that same cycle, it still uses the previous owner, and the new owner takes effect at the next visit.
- R9: A write whose cfg_client_i is 15 or above (not a valid client) is ignored, and the entry keeps its previous owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 15 | Request line for each client, bit n for client n |
| region_i | input | 1 | Region whose schedule and pointer serve this cycle |
| cfg_we_i | input | 1 | Schedule entry write strobe |
| cfg_region_i | input | 1 | Region of the entry written |
| cfg_slot_i | input | 6 | Slot number of the entry written |
| cfg_client_i | input | 4 | New owner index for the entry |
| gnt_o | output | 15 | Registered one-hot grant vector |
| gnt_valid_o | output | 1 | A grant is issued this cycle |
| gnt_idx_o | output | 4 | Index of the granted client |

## Verification
The first pattern uses all requests high on a region filled with a known owner pattern. The grant sequence then shows the slot walk: the step size, the wrap from 63 to 0, and the fact that an owner beats lower-index clients. A second pattern leaves the slot owner idle while a sparse set of clients requests, so the result comes only from the lowest-index fallback. Interleaving idle cycles and switching regions shows whether the pointers freeze and stay apart. A write aimed at the live slot tells old-owner from new-owner timing. Long runs of random, sparse requests and random writes (some of them invalid) are compared against a cycle-level bench model of the schedules and pointers.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int unsigned DEF_CLIENTS = 15;
  localparam int unsigned DEF_SLOTS   = 64;
  localparam int unsigned DEF_REGIONS = 2;

  // Source of a grant decision
  typedef enum logic {
    SRC_OWNER    = 1'b0,
    SRC_FALLBACK = 1'b1
  } grant_src_e;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slot_table.sv
module slot_table
  import slot_arb_pkg::*;
#(
  parameter int unsigned CLIENTS = DEF_CLIENTS,
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned REGIONS = DEF_REGIONS,
  localparam int unsigned CW      = width_of(CLIENTS),
  localparam int unsigned SW      = width_of(SLOTS),
  localparam int unsigned RGW     = width_of(REGIONS),
  localparam int unsigned ENTRIES = SLOTS * REGIONS,
  localparam int unsigned AW      = width_of(ENTRIES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RGW-1:0] wr_region,
  input  logic [SW-1:0]  wr_slot,
  input  logic [CW-1:0]  wr_client,
  input  logic [RGW-1:0] rd_region,
  input  logic [SW-1:0]  rd_slot,
  output logic [CW-1:0]  rd_client
);
  // Owner storage without reset, so it maps onto distributed RAM
  logic [CW-1:0]      mem_q [ENTRIES];
  // Per-entry "has been written" flags; a clear flag reads as client 0
  logic [ENTRIES-1:0] written_q;

  logic          wr_ok;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  assign wr_ok = wr_en
              && ({1'b0, wr_client} < (CW+1)'(CLIENTS))
              && ({1'b0, wr_region} < (RGW+1)'(REGIONS))
              && ({1'b0, wr_slot}   < (SW+1)'(SLOTS));

  assign wr_addr = AW'(wr_region) * AW'(SLOTS) + AW'(wr_slot);
  assign rd_addr = AW'(rd_region) * AW'(SLOTS) + AW'(rd_slot);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_q[wr_addr] <= wr_client;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
    end else if (wr_ok) begin
      written_q[wr_addr] <= 1'b1;
    end
  end

  // Read before write: a same-cycle write is seen only on the next visit
  always_comb begin
    rd_client = written_q[rd_addr] ? mem_q[rd_addr] : '0;
  end
endmodule

// File: rtl/slot_pointer.sv
module slot_pointer
  import slot_arb_pkg::*;
#(
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned REGIONS = DEF_REGIONS,
  localparam int unsigned SW  = width_of(SLOTS),
  localparam int unsigned RGW = width_of(REGIONS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           advance,
  input  logic [RGW-1:0] sel_region,
  output logic [SW-1:0]  cur_slot
);
  logic [REGIONS*SW-1:0] ptr_flat;

  for (genvar r = 0; r < REGIONS; r++) begin : gen_rg
    logic [SW-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q <= '0;
      end else if (advance && (sel_region == RGW'(r))) begin
        ptr_q <= (ptr_q == SW'(SLOTS - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
    assign ptr_flat[r*SW +: SW] = ptr_q;
  end

  assign cur_slot = ptr_flat[int'(sel_region)*SW +: SW];
endmodule

// File: rtl/fallback_pick.sv
module fallback_pick
  import slot_arb_pkg::*;
#(
  parameter int unsigned CLIENTS = DEF_CLIENTS,
  localparam int unsigned CW = width_of(CLIENTS)
) (
  input  logic [CLIENTS-1:0] req,
  output logic [CW-1:0]      idx
);
  // Lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int i = CLIENTS - 1; i >= 0; i--) begin
      if (req[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/slot_table_arbiter.sv
module slot_table_arbiter
  import slot_arb_pkg::*;
#(
  parameter int unsigned CLIENTS = DEF_CLIENTS,
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned REGIONS = DEF_REGIONS,
  localparam int unsigned CW  = width_of(CLIENTS),
  localparam int unsigned SW  = width_of(SLOTS),
  localparam int unsigned RGW = width_of(REGIONS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CLIENTS-1:0] req_i,
  input  logic [RGW-1:0]     region_i,
  input  logic               cfg_we_i,
  input  logic [RGW-1:0]     cfg_region_i,
  input  logic [SW-1:0]      cfg_slot_i,
  input  logic [CW-1:0]      cfg_client_i,
  output logic [CLIENTS-1:0] gnt_o,
  output logic               gnt_valid_o,
  output logic [CW-1:0]      gnt_idx_o
);
  logic [RGW-1:0] eff_region;
  logic [SW-1:0]  cur_slot;
  logic [CW-1:0]  owner_w;
  logic [CW-1:0]  fb_idx;
  logic           any_req;
  grant_src_e     src;
  logic [CW-1:0]  sel_idx;

  assign any_req    = |req_i;
  assign eff_region = ({1'b0, region_i} < (RGW+1)'(REGIONS)) ? region_i : '0;

  slot_pointer #(.SLOTS(SLOTS), .REGIONS(REGIONS)) ptr_i (
    .clk        (clk),
    .rst        (rst),
    .advance    (any_req),
    .sel_region (eff_region),
    .cur_slot   (cur_slot)
  );

  slot_table #(.CLIENTS(CLIENTS), .SLOTS(SLOTS), .REGIONS(REGIONS)) tbl_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we_i),
    .wr_region (cfg_region_i),
    .wr_slot   (cfg_slot_i),
    .wr_client (cfg_client_i),
    .rd_region (eff_region),
    .rd_slot   (cur_slot),
    .rd_client (owner_w)
  );

  fallback_pick #(.CLIENTS(CLIENTS)) fb_i (
    .req (req_i),
    .idx (fb_idx)
  );

  always_comb begin
    src     = (|(req_i & (CLIENTS'(1) << owner_w))) ? SRC_OWNER : SRC_FALLBACK;
    sel_idx = (src == SRC_OWNER) ? owner_w : fb_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o       <= '0;
      gnt_valid_o <= 1'b0;
      gnt_idx_o   <= '0;
    end else begin
      gnt_valid_o <= any_req;
      gnt_idx_o   <= any_req ? sel_idx : '0;
      gnt_o       <= any_req ? (CLIENTS'(1) << sel_idx) : '0;
    end
  end
endmodule

// File: rtl/slot_table_arbiter_chk.sv
module slot_table_arbiter_chk #(
  parameter int unsigned CLIENTS = 15,
  parameter int unsigned CW      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [CLIENTS-1:0] req_i,
  input logic [CLIENTS-1:0] gnt_o,
  input logic               gnt_valid_o,
  input logic [CW-1:0]      gnt_idx_o,
  input logic [CW-1:0]      owner_i
);
  assert_grant_shape_R2: assert property (@(posedge clk) disable iff (rst)
    gnt_valid_o |-> ($onehot0(gnt_o) && (gnt_o == (CLIENTS'(1) << gnt_idx_o))));

  assert_no_stray_grant_R5: assert property (@(posedge clk) disable iff (rst)
    !gnt_valid_o |-> (gnt_o == '0));

  assert_idle_no_grant_R5: assert property (@(posedge clk) disable iff (rst)
    !(|req_i) |=> !gnt_valid_o);

  assert_request_served_R2: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |=> (gnt_valid_o && ((($past(req_i) >> gnt_idx_o) & CLIENTS'(1)) != '0)));

  assert_owner_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (|(req_i & (CLIENTS'(1) << owner_i))) |=> (gnt_idx_o == $past(owner_i)));

  assert_fallback_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    ((|req_i) && !(|(req_i & (CLIENTS'(1) << owner_i))))
      |=> (($past(req_i) & ((CLIENTS'(1) << gnt_idx_o) - CLIENTS'(1))) == '0));
endmodule

bind slot_table_arbiter slot_table_arbiter_chk #(.CLIENTS(CLIENTS), .CW(CW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .gnt_valid_o (gnt_valid_o),
  .gnt_idx_o   (gnt_idx_o),
  .owner_i     (owner_w)
);

// File: tb/slot_table_arbiter_tb_top.sv
`timescale 1ns/1ps
module slot_table_arbiter_tb_top;
  localparam int NC = 15;
  localparam int NS = 64;
  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [NC-1:0] req_i;
  logic          region_i;
  logic          cfg_we_i;
  logic          cfg_region_i;
  logic [5:0]    cfg_slot_i;
  logic [3:0]    cfg_client_i;
  logic [NC-1:0] gnt_o;
  logic          gnt_valid_o;
  logic [3:0]    gnt_idx_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  int tbl [NR][NS];
  int ptr [NR];

  always #2.5 clk = ~clk;

  slot_table_arbiter dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .region_i(region_i),
    .cfg_we_i(cfg_we_i), .cfg_region_i(cfg_region_i),
    .cfg_slot_i(cfg_slot_i), .cfg_client_i(cfg_client_i),
    .gnt_o(gnt_o), .gnt_valid_o(gnt_valid_o), .gnt_idx_o(gnt_idx_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [NC-1:0] rq, input int owner);
    if (rq[owner]) return owner;
    for (int i = 0; i < NC; i++) if (rq[i]) return i;
    return -1;
  endfunction

  // Drive at a falling edge, update the model, sample at the next falling edge
  task automatic cycle(input logic [NC-1:0] rq, input int rg, input bit we,
                       input int wrg, input int wsl, input int wcl, input string tag);
    int exp_idx;
    req_i        = rq;
    region_i     = rg[0];
    cfg_we_i     = we;
    cfg_region_i = wrg[0];
    cfg_slot_i   = 6'(wsl);
    cfg_client_i = 4'(wcl);
    exp_idx = -1;
    if (rq != '0) begin
      exp_idx = pick(rq, tbl[rg][ptr[rg]]);
      ptr[rg] = (ptr[rg] + 1) % NS;
    end
    if (we && wcl < NC) tbl[wrg][wsl] = wcl;
    @(posedge clk);
    @(negedge clk);
    check(tag, "valid", int'(gnt_valid_o), (exp_idx >= 0) ? 1 : 0);
    if (exp_idx >= 0) begin
      check(tag, "index", int'(gnt_idx_o), exp_idx);
      check(tag, "vector", int'(gnt_o), 1 << exp_idx);
    end else begin
      check(tag, "vector", int'(gnt_o), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) begin
      ptr[r] = 0;
      for (int s = 0; s < NS; s++) tbl[r][s] = 0;
    end
    rst = 1'b1; req_i = '0; region_i = 1'b0; cfg_we_i = 1'b0;
    cfg_region_i = 1'b0; cfg_slot_i = '0; cfg_client_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "valid", int'(gnt_valid_o), 0);
    check("R1", "vector", int'(gnt_o), 0);
    cycle('1, 0, 0, 0, 0, 0, "R1");             // owner 0 everywhere
    cycle(15'h0280, 0, 0, 0, 0, 0, "R4");       // owner 0 idle -> client 7
    cycle('0, 0, 0, 0, 0, 0, "R5");             // idle, pointer holds
    cycle(15'h0010, 0, 0, 0, 0, 0, "R5");
    // R8: fill region 0 with slot % 15 while idle
    for (int s = 0; s < NS; s++) cycle('0, 0, 1, 0, s, s % NC, "R8");
    // R9: invalid owner value is dropped
    cycle('0, 0, 1, 0, 5, 15, "R9");
    cycle('0, 0, 1, 0, 20, 15, "R9");
    // R6 / R3: full walk with wrap, owners beat lower-index clients
    for (int k = 0; k < 2 * NS + 2; k++) cycle('1, 0, 0, 0, 0, 0, "R6");
    // R7: region 1 schedule untouched
    for (int k = 0; k < 4; k++) cycle('1, 1, 0, 0, 0, 0, "R7");
    cycle(15'h6000, 0, 0, 0, 0, 0, "R3");
    // R8: write the live slot of region 1 in the same cycle
    begin
      int live;
      live = ptr[1];
      cycle(15'h0028, 1, 1, 1, live, 5, "R8");  // old owner 0 idle -> 3
      for (int k = 0; k < NS - 1; k++) cycle('1, 1, 0, 0, 0, 0, "R6");
      cycle(15'h0028, 1, 0, 0, 0, 0, "R8");     // next visit -> 5
    end
    // Random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [NC-1:0] rq;
      rq = NC'($urandom) & NC'($urandom);
      if ($urandom % 6 == 0) rq = '0;
      cycle(rq, $urandom % NR, ($urandom % 4) == 0, $urandom % NR,
            $urandom % NS, $urandom % 16, "R2");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule